// File: doc/BRIEF.md
# Speculative Load Verification Commit Unit

This block is the retirement end of a processor that executes loads early and out of order but retires in program order. Upstream logic places entries into a small circular reorder buffer, oldest first. Each entry is one of three kinds:

- a non-memory operation;
- a store, carrying its address and data;
- a load that has already read memory speculatively, carrying the value it obtained.

Every entry also carries its own pc and the next pc that was predicted for it.

The oldest entry is retired only if its pc equals the pc the previous retired instruction said should come next. If it does not, the buffer is discarded and fetch is sent to the expected pc.

- A store touches memory for the first time when it reaches the oldest slot.
- A load reaching that slot is read again from memory. The second read is compared with the early value. If the two differ, the load retires with the newly read value, the buffer is discarded, and fetch restarts at the pc that follows the load.
- Only one such memory access is ever in flight. This keeps the memory traffic seen by other agents in program order.

Top module: `spec_commit_unit`

## Requirements
- R1: After reset the buffer is empty. `allocReady` is 1, and `memReqValid`, `commitValid` and `redirectValid` are 0. The expected pc is `ResetPc` (default 0).
- R2: `allocKind` encodes 0 as non-memory, 1 as load and 2 as store. A non-memory entry at the head with a matching pc retires in the cycle after it is allocated, raises no memory request, and retires at one per cycle in program order.
- R3: A store raises a request with `memReqWrite`=1, its address and its data only when it is at the head with a matching pc. It retires, with `commitData` equal to its data, in the cycle its acknowledgement arrives on `memRespValid`.
- R4: A load at the head with a matching pc raises a read request (`memReqWrite`=0) with its address. If the returned data equals the early value, it retires in the response cycle with that value and without redirect.
- R5: If a load's returned data differs from its early value, the load retires with the returned data in the response cycle. In the same cycle `redirectValid` rises with `redirectPc` = load pc + `PcStep` (default 4). In the next cycle the buffer is empty.
- R6: If the head entry's pc differs from the expected pc, it does not retire and raises no memory request. `redirectValid` rises with `redirectPc` equal to the expected pc, and the buffer is emptied.
- R7: While a request is outstanding (accepted but not yet answered), `memReqValid` stays 0.
- R8: The buffer holds 8 entries. With 8 held, `allocReady` is 0.
- R9: In a cycle with `redirectValid` high, `allocReady` is 0. An entry offered in that cycle is dropped.
- R10: A request that is not accepted stays valid with an unchanged address and write flag.
- R11: After a retirement the expected pc is the entry's predicted next pc. After a load value mismatch it is the load pc + `PcStep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Entry offered |
| allocReady | output | 1 | Entry can be taken |
| allocKind | input | 2 | 0 non-memory, 1 load, 2 store |
| allocPc | input | PcW | Entry pc |
| allocNextPc | input | PcW | Predicted next pc |
| allocAddr | input | AddrW | Memory address |
| allocData | input | DataW | Store data or early load value |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory takes request |
| memReqWrite | output | 1 | 1 store, 0 verification read |
| memReqAddr | output | AddrW | Request address |
| memReqData | output | DataW | Store data |
| memRespValid | input | 1 | Response or acknowledgement |
| memRespData | input | DataW | Read data |
| commitValid | output | 1 | Head entry retires |
| commitKind | output | 2 | Kind of retiring entry |
| commitPc | output | PcW | Pc of retiring entry |
| commitData | output | DataW | Value written back |
| redirectValid | output | 1 | Flush and refetch |
| redirectPc | output | PcW | Refetch pc |

## Verification
Two functions can coincide in one cycle:

- Allocation at the tail and retirement at the head. Non-memory entries are offered back to back, so each cycle both allocates one entry and retires the previous one; the retired pcs are judged in program order.
- A flush and a new allocation. An entry is offered in the very cycle a load returns a mismatching value. The bench checks that `allocReady` is low in that cycle, and that no retirement or request appears afterwards from the dropped entry or from the seven queued loads.

// File: rtl/sc_commit_pkg.sv
package sc_commit_pkg;

  typedef enum logic [1:0] {
    KIND_OP    = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_STORE = 2'd2
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic fixPc;
    logic useResp;
  } ctlStrobe_t;

endpackage

// File: rtl/sc_commit_datapath.sv
module sc_commit_datapath
  import sc_commit_pkg::*;
#(
  parameter int Depth   = 8,
  parameter int PcW     = 16,
  parameter int AddrW   = 16,
  parameter int DataW   = 16,
  parameter int PcStep  = 4,
  parameter int ResetPc = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [1:0]       allocKind,
  input  logic [PcW-1:0]   allocPc,
  input  logic [PcW-1:0]   allocNextPc,
  input  logic [AddrW-1:0] allocAddr,
  input  logic [DataW-1:0] allocData,
  input  logic [DataW-1:0] memRespData,
  output logic             headValid,
  output logic             full,
  output logic [1:0]       headKind,
  output logic             pcMatch,
  output logic             valMatch,
  output logic [PcW-1:0]   headPc,
  output logic [AddrW-1:0] headAddr,
  output logic [DataW-1:0] headData,
  output logic [PcW-1:0]   expPc,
  output logic [PcW-1:0]   fixPcVal,
  output logic [DataW-1:0] commitData
);

  localparam int IdxW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(Depth - 1);

  logic [1:0]       kindMem [Depth];
  logic [PcW-1:0]   pcMem   [Depth];
  logic [PcW-1:0]   nextMem [Depth];
  logic [AddrW-1:0] addrMem [Depth];
  logic [DataW-1:0] dataMem [Depth];

  logic [IdxW-1:0] headIdx, tailIdx;
  logic [CntW-1:0] count;
  logic [PcW-1:0]  expPcQ;

  // storage: one writable slot per entry
  for (genvar g = 0; g < Depth; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctl.push && tailIdx == IdxW'(g)) begin
        kindMem[g] <= allocKind;
        pcMem[g]   <= allocPc;
        nextMem[g] <= allocNextPc;
        addrMem[g] <= allocAddr;
        dataMem[g] <= allocData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
      expPcQ  <= PcW'(ResetPc);
    end else begin
      if (ctl.fixPc) begin
        expPcQ <= fixPcVal;
      end else if (ctl.pop) begin
        expPcQ <= nextMem[headIdx];
      end
      if (ctl.flush) begin
        headIdx <= '0;
        tailIdx <= '0;
        count   <= '0;
      end else begin
        if (ctl.push) tailIdx <= (tailIdx == LastIdx) ? '0 : tailIdx + 1'b1;
        if (ctl.pop)  headIdx <= (headIdx == LastIdx) ? '0 : headIdx + 1'b1;
        count <= count + CntW'(ctl.push) - CntW'(ctl.pop);
      end
    end
  end

  always_comb begin
    headValid  = (count != '0);
    full       = (count == CntW'(Depth));
    headKind   = kindMem[headIdx];
    headPc     = pcMem[headIdx];
    headAddr   = addrMem[headIdx];
    headData   = dataMem[headIdx];
    expPc      = expPcQ;
    pcMatch    = (headPc == expPcQ);
    valMatch   = (memRespData == headData);
    fixPcVal   = headPc + PcW'(PcStep);
    commitData = ctl.useResp ? memRespData : headData;
  end

endmodule

// File: rtl/sc_commit_control.sv
module sc_commit_control
  import sc_commit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       headValid,
  input  logic       full,
  input  logic [1:0] headKind,
  input  logic       pcMatch,
  input  logic       valMatch,
  input  logic       allocValid,
  input  logic       memReqReady,
  input  logic       memRespValid,
  output ctlStrobe_t ctl,
  output logic       allocReady,
  output logic       memReqValid,
  output logic       commitValid,
  output logic       redirectValid
);

  logic busy;
  logic isMem, isLoad, pcBad, respHit, loadBad, commitOp;

  always_comb begin
    isMem    = (headKind == KIND_LOAD) || (headKind == KIND_STORE);
    isLoad   = (headKind == KIND_LOAD);
    pcBad    = headValid && !busy && !pcMatch;
    commitOp = headValid && !busy && pcMatch && !isMem;
    respHit  = busy && memRespValid;
    loadBad  = respHit && isLoad && !valMatch;

    memReqValid   = headValid && !busy && pcMatch && isMem;
    commitValid   = commitOp || respHit;
    redirectValid = pcBad || loadBad;
    allocReady    = !full && !redirectValid;

    ctl.push    = allocValid && allocReady;
    ctl.pop     = commitValid;
    ctl.flush   = redirectValid;
    ctl.fixPc   = loadBad;
    ctl.useResp = respHit && isLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (memReqValid && memReqReady) begin
      busy <= 1'b1;
    end else if (respHit) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/spec_commit_unit.sv
module spec_commit_unit
  import sc_commit_pkg::*;
#(
  parameter int Depth   = 8,
  parameter int PcW     = 16,
  parameter int AddrW   = 16,
  parameter int DataW   = 16,
  parameter int PcStep  = 4,
  parameter int ResetPc = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  output logic             allocReady,
  input  logic [1:0]       allocKind,
  input  logic [PcW-1:0]   allocPc,
  input  logic [PcW-1:0]   allocNextPc,
  input  logic [AddrW-1:0] allocAddr,
  input  logic [DataW-1:0] allocData,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic             memReqWrite,
  output logic [AddrW-1:0] memReqAddr,
  output logic [DataW-1:0] memReqData,
  input  logic             memRespValid,
  input  logic [DataW-1:0] memRespData,
  output logic             commitValid,
  output logic [1:0]       commitKind,
  output logic [PcW-1:0]   commitPc,
  output logic [DataW-1:0] commitData,
  output logic             redirectValid,
  output logic [PcW-1:0]   redirectPc
);

  ctlStrobe_t       ctl;
  logic             headValid, full, pcMatch, valMatch;
  logic [1:0]       headKind;
  logic [PcW-1:0]   headPc, expPc, fixPcVal;
  logic [AddrW-1:0] headAddr;
  logic [DataW-1:0] headData;

  sc_commit_datapath #(
    .Depth(Depth), .PcW(PcW), .AddrW(AddrW), .DataW(DataW),
    .PcStep(PcStep), .ResetPc(ResetPc)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .allocKind(allocKind), .allocPc(allocPc), .allocNextPc(allocNextPc),
    .allocAddr(allocAddr), .allocData(allocData), .memRespData(memRespData),
    .headValid(headValid), .full(full), .headKind(headKind),
    .pcMatch(pcMatch), .valMatch(valMatch), .headPc(headPc),
    .headAddr(headAddr), .headData(headData), .expPc(expPc),
    .fixPcVal(fixPcVal), .commitData(commitData)
  );

  sc_commit_control u_ctl (
    .clk(clk), .rstN(rstN), .headValid(headValid), .full(full),
    .headKind(headKind), .pcMatch(pcMatch), .valMatch(valMatch),
    .allocValid(allocValid), .memReqReady(memReqReady),
    .memRespValid(memRespValid), .ctl(ctl), .allocReady(allocReady),
    .memReqValid(memReqValid), .commitValid(commitValid),
    .redirectValid(redirectValid)
  );

  assign memReqWrite = (headKind == KIND_STORE);
  assign memReqAddr  = headAddr;
  assign memReqData  = headData;
  assign commitKind  = headKind;
  assign commitPc    = headPc;
  assign redirectPc  = ctl.fixPc ? fixPcVal : expPc;

endmodule

// File: rtl/sc_commit_checker.sv
module sc_commit_checker #(
  parameter int AddrW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocReady,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic             memReqWrite,
  input logic [AddrW-1:0] memReqAddr,
  input logic             memRespValid,
  input logic             commitValid,
  input logic [1:0]       commitKind,
  input logic             redirectValid
);

  logic outst;

  always_ff @(posedge clk) begin
    if (!rstN) outst <= 1'b0;
    else if (memReqValid && memReqReady) outst <= 1'b1;
    else if (memRespValid) outst <= 1'b0;
  end

  p_single_flight_r7: assert property (@(posedge clk) disable iff (!rstN)
    outst |-> !memReqValid);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=>
      memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  p_flush_blocks_alloc_r9: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !allocReady);

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !commitValid && !memReqValid);

  p_mem_retire_on_resp_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && commitKind != 2'd0 |-> memRespValid && outst);

  p_pc_fix_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid && !commitValid |-> !memReqValid);

  p_op_no_traffic_r2: assert property (@(posedge clk) disable iff (!rstN)
    commitValid && commitKind == 2'd0 |-> !memReqValid);

endmodule

bind spec_commit_unit sc_commit_checker #(.AddrW(AddrW)) u_chk (
  .clk(clk), .rstN(rstN), .allocReady(allocReady),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memRespValid(memRespValid), .commitValid(commitValid),
  .commitKind(commitKind), .redirectValid(redirectValid)
);

// File: tb/tb_spec_commit_unit.sv
module tb_spec_commit_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic        allocReady;
  logic [1:0]  allocKind = 2'd0;
  logic [15:0] allocPc = '0, allocNextPc = '0, allocAddr = '0, allocData = '0;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [15:0] memReqAddr, memReqData;
  logic        memRespValid = 1'b0;
  logic [15:0] memRespData = '0;
  logic        commitValid, redirectValid;
  logic [1:0]  commitKind;
  logic [15:0] commitPc, commitData, redirectPc;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  spec_commit_unit dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
    .allocKind(allocKind), .allocPc(allocPc), .allocNextPc(allocNextPc),
    .allocAddr(allocAddr), .allocData(allocData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memRespValid(memRespValid),
    .memRespData(memRespData), .commitValid(commitValid),
    .commitKind(commitKind), .commitPc(commitPc), .commitData(commitData),
    .redirectValid(redirectValid), .redirectPc(redirectPc)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        wrongPc;
    logic [15:0] nextPc;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] resp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 16'h0004, 16'h0000, 16'h0000, 16'h0000},
    '{2'd0, 1'b0, 16'h0040, 16'h0000, 16'h0007, 16'h0000},
    '{2'd2, 1'b0, 16'h0044, 16'h0100, 16'hBEEF, 16'h0000},
    '{2'd1, 1'b0, 16'h0048, 16'h0100, 16'h1234, 16'h1234},
    '{2'd1, 1'b0, 16'h0080, 16'h0104, 16'h1111, 16'h2222},
    '{2'd0, 1'b1, 16'h0090, 16'h0000, 16'h0000, 16'h0000},
    '{2'd0, 1'b0, 16'h0050, 16'h0000, 16'h0000, 16'h0000},
    '{2'd1, 1'b0, 16'h0054, 16'h0108, 16'hAAAA, 16'hAAAA}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    logic [15:0] mPc;
    logic [15:0] pcUse;
    mPc = 16'h0000;

    // reset state (R1)
    repeat (3) step();
    rstN = 1'b1;
    #1;
    chk(allocReady && !memReqValid && !commitValid && !redirectValid, "R1",
        {allocReady, memReqValid, commitValid, redirectValid}, 4'b1000);

    // vector table
    for (int i = 0; i < 8; i++) begin
      pcUse       = VECS[i].wrongPc ? (mPc + 16'h0100) : mPc;
      allocValid  = 1'b1;
      allocKind   = VECS[i].kind;
      allocPc     = pcUse;
      allocNextPc = VECS[i].nextPc;
      allocAddr   = VECS[i].addr;
      allocData   = VECS[i].data;
      step();
      allocValid = 1'b0;
      #1;
      if (VECS[i].wrongPc) begin
        chk(redirectValid && redirectPc == mPc && !commitValid && !memReqValid,
            "R6", redirectPc, mPc);
        step();
        #1;
        chk(!commitValid && !memReqValid && allocReady, "R6",
            {commitValid, memReqValid}, 0);
      end else if (VECS[i].kind == 2'd0) begin
        chk(commitValid && commitPc == pcUse && !memReqValid, "R2",
            commitPc, pcUse);
        // R11: next entry must match the predicted next pc
        mPc = VECS[i].nextPc;
        step();
      end else begin
        chk(memReqValid && memReqWrite == (VECS[i].kind == 2'd2) &&
            memReqAddr == VECS[i].addr, VECS[i].kind == 2'd2 ? "R3" : "R4",
            memReqAddr, VECS[i].addr);
        if (VECS[i].kind == 2'd2)
          chk(memReqData == VECS[i].data, "R3", memReqData, VECS[i].data);
        chk(!commitValid, "R3", commitValid, 0);
        memReqReady = 1'b1;
        step();
        memReqReady = 1'b0;
        #1;
        chk(!memReqValid && !commitValid, "R7", memReqValid, 0);
        memRespValid = 1'b1;
        memRespData  = VECS[i].resp;
        #1;
        if (VECS[i].kind == 2'd2) begin
          chk(commitValid && commitData == VECS[i].data && !redirectValid,
              "R3", commitData, VECS[i].data);
          mPc = VECS[i].nextPc;
        end else if (VECS[i].resp == VECS[i].data) begin
          chk(commitValid && commitData == VECS[i].resp && !redirectValid,
              "R4", commitData, VECS[i].resp);
          mPc = VECS[i].nextPc;
        end else begin
          chk(commitValid && commitData == VECS[i].resp, "R5",
              commitData, VECS[i].resp);
          chk(redirectValid && redirectPc == pcUse + 16'd4, "R5",
              redirectPc, pcUse + 16'd4);
          mPc = pcUse + 16'd4;
        end
        step();
        memRespValid = 1'b0;
      end
    end

    // back-to-back allocation and retirement (R2)
    for (int i = 0; i < 4; i++) begin
      allocValid  = 1'b1;
      allocKind   = 2'd0;
      allocPc     = mPc + 16'(4 * i);
      allocNextPc = mPc + 16'(4 * i + 4);
      #1;
      if (i > 0)
        chk(commitValid && commitPc == mPc + 16'(4 * (i - 1)), "R2",
            commitPc, mPc + 16'(4 * (i - 1)));
      step();
    end
    allocValid = 1'b0;
    #1;
    chk(commitValid && commitPc == mPc + 16'd12, "R2", commitPc, mPc + 16'd12);
    step();
    mPc = mPc + 16'd16;

    // fill to capacity with loads while the memory stalls (R8, R10)
    memReqReady = 1'b0;
    for (int i = 0; i < 8; i++) begin
      allocValid  = 1'b1;
      allocKind   = 2'd1;
      allocPc     = mPc + 16'(4 * i);
      allocNextPc = mPc + 16'(4 * i + 4);
      allocAddr   = 16'h0200 + 16'(4 * i);
      allocData   = 16'h0010 + 16'(i);
      #1;
      if (i > 1)
        chk(memReqValid && memReqAddr == 16'h0200 && !memReqWrite, "R10",
            memReqAddr, 16'h0200);
      step();
    end
    allocValid = 1'b0;
    #1;
    chk(!allocReady, "R8", allocReady, 0);
    memReqReady = 1'b1;
    step();
    memReqReady = 1'b0;
    #1;
    chk(!memReqValid, "R7", memReqValid, 0);
    step();
    #1;
    chk(!memReqValid && !commitValid, "R7", memReqValid, 0);
    memRespValid = 1'b1;
    memRespData  = 16'h0010;
    #1;
    chk(commitValid && commitPc == mPc && !redirectValid, "R4", commitPc, mPc);
    step();
    memRespValid = 1'b0;
    #1;
    chk(memReqValid && memReqAddr == 16'h0204 && allocReady, "R4",
        memReqAddr, 16'h0204);
    memReqReady = 1'b1;
    step();
    memReqReady = 1'b0;

    // mismatch flush together with an offered entry (R5, R9)
    memRespValid = 1'b1;
    memRespData  = 16'h0099;
    allocValid   = 1'b1;
    allocKind    = 2'd0;
    allocPc      = mPc + 16'd8;
    allocNextPc  = 16'h0300;
    #1;
    chk(!allocReady, "R9", allocReady, 0);
    chk(redirectValid && redirectPc == mPc + 16'd8 && commitValid &&
        commitData == 16'h0099, "R5", redirectPc, mPc + 16'd8);
    step();
    allocValid   = 1'b0;
    memRespValid = 1'b0;
    #1;
    chk(!commitValid && !memReqValid && allocReady && !redirectValid, "R5",
        {commitValid, memReqValid, allocReady}, 3'b001);
    step();
    #1;
    chk(!commitValid && !memReqValid, "R9", commitValid, 0);

    // expected pc after the value fix (R11)
    mPc         = mPc + 16'd8;
    allocValid  = 1'b1;
    allocKind   = 2'd0;
    allocPc     = mPc;
    allocNextPc = 16'h0300;
    step();
    allocValid = 1'b0;
    #1;
    chk(commitValid && commitPc == mPc && !redirectValid, "R11", commitPc, mPc);
    step();
    #1;
    chk(!commitValid && !redirectValid, "R11", commitValid, 0);

    finishRun();
  end

endmodule